// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This block works out the program counter that follows each instruction of a small 8-bit controller core. For every instruction it receives the decoded instruction class, up to two operand bytes, the current PC, the instruction length in bytes, the accumulator, the carry flag and the value of the loop counter register. From these it produces the next PC. For loop instructions it also returns the decremented counter with a write strobe. For calls and returns it drives push and pop requests to an internal return-address stack.

A branch target is formed in one of three ways. A short relative branch adds a signed 8-bit displacement to the fall-through address, which is the current PC plus the length. A long jump or long call takes a full 16-bit address. A page call replaces the low 11 bits of the fall-through address. Every call saves the fall-through address, and a return restores it. The return-address stack holds 8 addresses of 16 bits. It reports an overflow when a push finds it full and an underflow when a pop finds it empty.

Classes are coded on `instClass` as follows: 0 sequential, 1 short jump, 2 jump-if-zero, 3 jump-if-nonzero, 4 jump-if-no-carry, 5 decrement-and-branch, 6 long jump, 7 long call, 8 page call, 9 return. A 16-bit target arrives as `{opByte1, opByte2}`. An 11-bit target arrives as `{opByte1[2:0], opByte2}`. A relative displacement arrives in `opByte1`.

Top module: `flow_next_pc`

## Requirements
- R1: When `instValid` is low, or the class is 0 (sequential), `nextPc` equals `curPc + instLen` modulo 2^16. In that case no push, pop or counter write is requested.
- R2: Class 1 (short jump) always branches. The target is `curPc + instLen` plus `opByte1` read as a signed value from -128 to +127, with the sum wrapping modulo 2^16.
- R3: Class 2 branches to the relative target only when `accVal` is zero. Class 3 branches only when `accVal` is nonzero. When the branch is not taken, `nextPc` is the fall-through address.
- R4: Class 4 branches to the relative target when `carryFlag` is 0. When `carryFlag` is 1 it falls through.
- R5: Class 5 drives `loopCountNext = loopCount - 1` modulo 256 with `loopCountWe` high. It branches to the relative target only when that result is nonzero, so a start value of 0 gives 256 passes.
- R6: Class 6 (long jump) sets `nextPc = {opByte1, opByte2}` and requests no push.
- R7: Class 7 (long call) sets `nextPc = {opByte1, opByte2}`, raises `pushReq`, and saves `curPc + instLen` on the stack.
- R8: Class 8 (page call) sets `nextPc` to bits 15:11 of `curPc + instLen` concatenated with `{opByte1[2:0], opByte2}`. It raises `pushReq` and saves the fall-through address.
- R9: Class 9 (return) raises `popReq`. It sets `nextPc` to the most recently saved address that has not yet been popped, so addresses come back in last-in first-out order.
- R10: A call made while 8 addresses are already saved raises `stackOverflow` in that cycle. The new address is dropped, the saved addresses are kept, and `nextPc` still goes to the call target.
- R11: A return made while the stack is empty raises `stackUnderflow` in that cycle and sets `nextPc = curPc + instLen`.
- R12: After reset the stack is empty, so the first return underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is presented this cycle |
| instClass | input | 4 | Decoded instruction class, coded 0..9 |
| opByte1 | input | 8 | First operand byte |
| opByte2 | input | 8 | Second operand byte |
| curPc | input | 16 | Address of the current instruction |
| instLen | input | 2 | Instruction length in bytes |
| accVal | input | 8 | Accumulator value |
| carryFlag | input | 1 | Carry flag |
| loopCount | input | 8 | Current loop counter value |
| nextPc | output | 16 | Address of the next instruction |
| loopCountNext | output | 8 | Decremented loop counter |
| loopCountWe | output | 1 | Write strobe for the loop counter |
| pushReq | output | 1 | Call saves a return address |
| popReq | output | 1 | Return restores an address |
| stackOverflow | output | 1 | Push attempted on a full stack |
| stackUnderflow | output | 1 | Pop attempted on an empty stack |

## Verification
The bench places relative targets on both sides of the 64K wrap. A unit that used an unsigned displacement, or that added it to the branch's own address instead of the fall-through address, would land on the wrong address. It runs a decrement loop from a start value of 0 and counts 256 passes; a unit that tested the counter before decrementing would stop at once. It fills the stack beyond eight entries and then drains it: a stack that wrapped would return a corrupted address after the overflow, and one that ignored underflow would jump to a stale entry. Page calls are placed so that the fall-through address crosses into the next 2K page, which separates the correct page from the page of the call itself.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic [3:0] {
    CLS_SEQ   = 4'd0,
    CLS_SJMP  = 4'd1,
    CLS_JZ    = 4'd2,
    CLS_JNZ   = 4'd3,
    CLS_JNC   = 4'd4,
    CLS_DJNZ  = 4'd5,
    CLS_LJMP  = 4'd6,
    CLS_LCALL = 4'd7,
    CLS_ACALL = 4'd8,
    CLS_RET   = 4'd9
  } instClass_e;

  typedef struct packed {
    logic selRel;
    logic selLong;
    logic selPage;
    logic selPop;
    logic push;
    logic pop;
    logic cntWe;
  } flowStrobe_t;
endpackage

// File: rtl/flow_ctrl.sv
module flow_ctrl
  import flow_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        instClass,
  input  logic [DATA_W-1:0] accVal,
  input  logic              carryFlag,
  input  logic [CNT_W-1:0]  loopCount,
  input  logic              stackEmpty,
  input  logic              stackFull,
  output flowStrobe_t       strobe,
  output logic [CNT_W-1:0]  cntNext,
  output logic              overflow,
  output logic              underflow
);
  instClass_e cls;
  assign cls = instClass_e'(instClass);

  always_comb begin
    strobe  = '0;
    cntNext = loopCount - 1'b1;
    if (instValid) begin
      case (cls)
        CLS_SJMP:  strobe.selRel = 1'b1;
        CLS_JZ:    strobe.selRel = (accVal == '0);
        CLS_JNZ:   strobe.selRel = (accVal != '0);
        CLS_JNC:   strobe.selRel = !carryFlag;
        CLS_DJNZ: begin
          strobe.cntWe  = 1'b1;
          strobe.selRel = (cntNext != '0);
        end
        CLS_LJMP:  strobe.selLong = 1'b1;
        CLS_LCALL: begin
          strobe.selLong = 1'b1;
          strobe.push    = 1'b1;
        end
        CLS_ACALL: begin
          strobe.selPage = 1'b1;
          strobe.push    = 1'b1;
        end
        CLS_RET: begin
          strobe.pop    = 1'b1;
          strobe.selPop = !stackEmpty;
        end
        default: ;
      endcase
    end
  end

  assign overflow  = strobe.push && stackFull;
  assign underflow = strobe.pop && stackEmpty;

  // R1: at most one target source is chosen per instruction
  p_one_target_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selRel, strobe.selLong, strobe.selPage, strobe.selPop}));
  // R9: push and pop never requested together
  p_no_push_pop_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.push && strobe.pop));
endmodule

// File: rtl/flow_datapath.sv
module flow_datapath
  import flow_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BYTE_W = 8,
  parameter int PAGE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  flowStrobe_t       strobe,
  input  logic [PC_W-1:0]   curPc,
  input  logic [1:0]        instLen,
  input  logic [BYTE_W-1:0] opByte1,
  input  logic [BYTE_W-1:0] opByte2,
  input  logic [PC_W-1:0]   stackTop,
  output logic [PC_W-1:0]   fallThru,
  output logic [PC_W-1:0]   nextPc
);
  localparam int HI_W = PAGE_W - BYTE_W;

  logic [PC_W-1:0] relTgt;
  logic [PC_W-1:0] longTgt;
  logic [PC_W-1:0] pageTgt;

  assign fallThru = curPc + PC_W'(instLen);
  assign relTgt   = fallThru + {{(PC_W-BYTE_W){opByte1[BYTE_W-1]}}, opByte1};
  assign longTgt  = PC_W'({opByte1, opByte2});
  assign pageTgt  = {fallThru[PC_W-1:PAGE_W], opByte1[HI_W-1:0], opByte2};

  always_comb begin
    if (strobe.selRel)       nextPc = relTgt;
    else if (strobe.selLong) nextPc = longTgt;
    else if (strobe.selPage) nextPc = pageTgt;
    else if (strobe.selPop)  nextPc = stackTop;
    else                     nextPc = fallThru;
  end

  // R1: with no target selected, the distance to the next PC is the length
  p_seq_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.selRel || strobe.selLong || strobe.selPage || strobe.selPop)
      |-> (nextPc - curPc) == PC_W'(instLen));
  // R8: a page target stays in the page of the fall-through address
  p_page_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selPage |-> nextPc[PC_W-1:PAGE_W] == fallThru[PC_W-1:PAGE_W]);
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] pushData,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] fill;

  assign empty = (fill == '0);
  assign full  = (fill == CNT_W'(DEPTH));
  assign top   = mem[IDX_W'(fill - 1'b1)];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fill <= '0;
    end else if (push && !full) begin
      mem[IDX_W'(fill)] <= pushData;
      fill <= fill + 1'b1;
    end else if (pop && !empty) begin
      fill <= fill - 1'b1;
    end
  end

  // R10: the fill level never passes the depth
  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CNT_W'(DEPTH));
  // R10: a push on a full stack leaves its contents unchanged
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    push && full |=> $stable(fill) && $stable(top));
  // R9: the address pushed last is on top in the next cycle
  p_lifo_top_r9: assert property (@(posedge clk) disable iff (!rstN)
    push && !full |=> top == $past(pushData));
  // R11: popping an empty stack keeps it empty
  p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    pop && empty |=> empty);
endmodule

// File: rtl/flow_next_pc.sv
module flow_next_pc
  import flow_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int BYTE_W  = 8,
  parameter int PAGE_W  = 11,
  parameter int STACK_D = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        instClass,
  input  logic [BYTE_W-1:0] opByte1,
  input  logic [BYTE_W-1:0] opByte2,
  input  logic [PC_W-1:0]   curPc,
  input  logic [1:0]        instLen,
  input  logic [BYTE_W-1:0] accVal,
  input  logic              carryFlag,
  input  logic [BYTE_W-1:0] loopCount,
  output logic [PC_W-1:0]   nextPc,
  output logic [BYTE_W-1:0] loopCountNext,
  output logic              loopCountWe,
  output logic              pushReq,
  output logic              popReq,
  output logic              stackOverflow,
  output logic              stackUnderflow
);
  flowStrobe_t     strobe;
  logic            stackEmpty;
  logic            stackFull;
  logic [PC_W-1:0] stackTop;
  logic [PC_W-1:0] fallThru;

  flow_ctrl #(.DATA_W(BYTE_W), .CNT_W(BYTE_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .instClass  (instClass),
    .accVal     (accVal),
    .carryFlag  (carryFlag),
    .loopCount  (loopCount),
    .stackEmpty (stackEmpty),
    .stackFull  (stackFull),
    .strobe     (strobe),
    .cntNext    (loopCountNext),
    .overflow   (stackOverflow),
    .underflow  (stackUnderflow)
  );

  flow_datapath #(.PC_W(PC_W), .BYTE_W(BYTE_W), .PAGE_W(PAGE_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .curPc    (curPc),
    .instLen  (instLen),
    .opByte1  (opByte1),
    .opByte2  (opByte2),
    .stackTop (stackTop),
    .fallThru (fallThru),
    .nextPc   (nextPc)
  );

  ret_stack #(.DEPTH(STACK_D), .W(PC_W)) i_stack (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.push),
    .pop      (strobe.pop),
    .pushData (fallThru),
    .top      (stackTop),
    .empty    (stackEmpty),
    .full     (stackFull)
  );

  assign loopCountWe = strobe.cntWe;
  assign pushReq     = strobe.push;
  assign popReq      = strobe.pop;
endmodule

// File: tb/test_flow_next_pc.sv
module test_flow_next_pc;
  logic        clk = 1'b0;
  logic        rstN;
  logic        instValid;
  logic [3:0]  instClass;
  logic [7:0]  opByte1, opByte2, accVal, loopCount;
  logic [15:0] curPc;
  logic [1:0]  instLen;
  logic        carryFlag;
  logic [15:0] nextPc;
  logic [7:0]  loopCountNext;
  logic        loopCountWe, pushReq, popReq, stackOverflow, stackUnderflow;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flow_next_pc i_flow_next_pc (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .opByte1(opByte1), .opByte2(opByte2), .curPc(curPc), .instLen(instLen),
    .accVal(accVal), .carryFlag(carryFlag), .loopCount(loopCount),
    .nextPc(nextPc), .loopCountNext(loopCountNext), .loopCountWe(loopCountWe),
    .pushReq(pushReq), .popReq(popReq), .stackOverflow(stackOverflow),
    .stackUnderflow(stackUnderflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // present one instruction after the falling edge, sample 1 ns later
  task automatic issue(input logic [3:0] cls, input logic [15:0] pc, input logic [1:0] len,
                       input logic [7:0] b1, input logic [7:0] b2,
                       input logic [7:0] acc, input logic cy, input logic [7:0] cnt);
    @(negedge clk);
    instValid = 1'b1; instClass = cls; curPc = pc; instLen = len;
    opByte1 = b1; opByte2 = b2; accVal = acc; carryFlag = cy; loopCount = cnt;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    instValid = 1'b0; instClass = 4'd0;
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); instValid = 1'b0; curPc = 16'h1234; instLen = 2'd2; #1;
    chk("R1 idle nextPc", nextPc, 16'h1236);
    chk("R1 idle strobes", {pushReq, popReq, loopCountWe}, 0);
    issue(4'd0, 16'hFFFF, 2'd3, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R1 sequential wrap", nextPc, 16'h0002);
    issue(4'd9, 16'h0400, 2'd1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R12 first return underflows", stackUnderflow, 1);
    chk("R11 underflow falls through", nextPc, 16'h0401);
    chk("R9 popReq", popReq, 1);
    idle();
  endtask

  task automatic t_short();
    issue(4'd1, 16'h0100, 2'd2, 8'h10, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R2 forward", nextPc, 16'h0112);
    issue(4'd1, 16'h0100, 2'd2, 8'h80, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R2 most negative", nextPc, 16'h0082);
    issue(4'd1, 16'hFFF0, 2'd2, 8'h20, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R2 wrap up", nextPc, 16'h0012);
    issue(4'd1, 16'h0000, 2'd2, 8'hF0, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R2 wrap down", nextPc, 16'hFFF2);
  endtask

  task automatic t_cond();
    issue(4'd2, 16'h0200, 2'd2, 8'h05, 8'h00, 8'h00, 1'b1, 8'h00);
    chk("R3 jz taken", nextPc, 16'h0207);
    issue(4'd2, 16'h0200, 2'd2, 8'h05, 8'h00, 8'h03, 1'b1, 8'h00);
    chk("R3 jz not taken", nextPc, 16'h0202);
    issue(4'd3, 16'h0200, 2'd2, 8'h05, 8'h00, 8'h80, 1'b1, 8'h00);
    chk("R3 jnz taken", nextPc, 16'h0207);
    issue(4'd3, 16'h0200, 2'd2, 8'h05, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R3 jnz not taken", nextPc, 16'h0202);
    issue(4'd4, 16'h0200, 2'd2, 8'hFC, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R4 jnc taken", nextPc, 16'h01FE);
    issue(4'd4, 16'h0200, 2'd2, 8'hFC, 8'h00, 8'h00, 1'b1, 8'h00);
    chk("R4 jnc falls", nextPc, 16'h0202);
  endtask

  task automatic t_loop();
    logic [7:0] cnt;
    int passes;
    issue(4'd5, 16'h0300, 2'd2, 8'hFE, 8'h00, 8'h00, 1'b0, 8'd5);
    chk("R5 count dec", loopCountNext, 8'd4);
    chk("R5 write strobe", loopCountWe, 1);
    chk("R5 taken", nextPc, 16'h0300);
    issue(4'd5, 16'h0300, 2'd2, 8'hFE, 8'h00, 8'h00, 1'b0, 8'd1);
    chk("R5 exit at zero", nextPc, 16'h0302);
    chk("R5 exit count", loopCountNext, 8'd0);
    cnt = 8'd0; passes = 0;
    for (int k = 0; k < 300; k++) begin
      issue(4'd5, 16'h0300, 2'd2, 8'hFE, 8'h00, 8'h00, 1'b0, cnt);
      passes++;
      cnt = loopCountNext;
      if (nextPc != 16'h0300) break;
    end
    chk("R5 start 0 runs 256 passes", passes, 256);
  endtask

  task automatic t_calls();
    issue(4'd6, 16'h0010, 2'd3, 8'hAB, 8'hCD, 8'h00, 1'b0, 8'h00);
    chk("R6 long jump", nextPc, 16'hABCD);
    chk("R6 no push", pushReq, 0);
    issue(4'd7, 16'h1000, 2'd3, 8'h45, 8'h67, 8'h00, 1'b0, 8'h00);
    chk("R7 long call target", nextPc, 16'h4567);
    chk("R7 push", pushReq, 1);
    chk("R10 no overflow", stackOverflow, 0);
    issue(4'd8, 16'h2FFE, 2'd2, 8'h05, 8'h34, 8'h00, 1'b0, 8'h00);
    chk("R8 page call", nextPc, 16'h3534);
    issue(4'd8, 16'h37FF, 2'd2, 8'hFF, 8'hFF, 8'h00, 1'b0, 8'h00);
    chk("R8 page of fall-through", nextPc, 16'h3FFF);
    issue(4'd9, 16'h0500, 2'd1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R9 return 1", nextPc, 16'h3801);
    chk("R11 no underflow", stackUnderflow, 0);
    issue(4'd9, 16'h0500, 2'd1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R9 return 2", nextPc, 16'h3000);
    issue(4'd9, 16'h0500, 2'd1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R9 return 3", nextPc, 16'h1003);
    idle();
  endtask

  task automatic t_stack_limits();
    for (int i = 1; i <= 8; i++) begin
      issue(4'd7, 16'(i * 256), 2'd3, 8'h80, 8'h00, 8'h00, 1'b0, 8'h00);
      if (stackOverflow) chk("R10 early overflow", 1, 0);
    end
    issue(4'd7, 16'h0900, 2'd3, 8'h80, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R10 overflow flag", stackOverflow, 1);
    chk("R10 still jumps", nextPc, 16'h8000);
    for (int i = 8; i >= 1; i--) begin
      issue(4'd9, 16'h5000, 2'd1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00);
      chk("R9 R10 lifo after overflow", nextPc, i * 256 + 3);
    end
    issue(4'd9, 16'h5000, 2'd1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R11 underflow flag", stackUnderflow, 1);
    chk("R11 underflow nextPc", nextPc, 16'h5001);
    idle();
  endtask

  initial begin
    #800000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; instValid = 1'b0; instClass = 4'd0; curPc = '0; instLen = 2'd1;
    opByte1 = '0; opByte2 = '0; accVal = '0; carryFlag = 1'b0; loopCount = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    t_reset();
    t_short();
    t_cond();
    t_loop();
    t_calls();
    t_stack_limits();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule